// File: doc/BRIEF.md
# Track Code Bus Direction Arbiter

This block steers a shared bidirectional track-code bus in each of four quadrants. Two devices can drive that bus. One is a buffer on the host-bus side, enabled by an active-low control. The other is a buffer on the RAM side, enabled by an active-high control. For every quadrant the block computes both enables and registers them, so that at most one direction is chosen on purpose at any time.

When no RAM access is in progress, a 2-bit source register picks the enable pair. The four values are:

- 00: simulated codes from the bus-side buffer.
- 01: an invalid pair.
- 10: no driver.
- 11: RAM codes.

A host read or write of a quadrant's track-code RAM overrides that choice for the quadrant involved only. A read opens the RAM-to-bus path. A write opens the bus-to-RAM path. The override reduces to a read gate that idles high and a write gate that idles low, feeding a 2-to-1 mux that is steered by the register bit.

The source register sits on a small register port at a fixed offset. A synchronized copy of the asynchronous reset clears the block.

Top module: `tkc_dir_arb`

## Requirements
- R1: After reset the source register reads 2'b10, and every quadrant shows bus_oe_n=1 and ram_oe=0.
- R2: With no qualified access, the registered pair {bus_oe_n, ram_oe} of each quadrant equals the source register: 00 gives 0/0, 01 gives 0/1, 10 gives 1/0 and 11 gives 1/1.
- R3: A qualified read of a quadrant forces bus_oe_n=1 and ram_oe=1 for that quadrant, whatever the source register holds.
- R4: A qualified write (write-wait high, read-wait low) forces bus_oe_n=0 and ram_oe=0 for that quadrant, whatever the source register holds.
- R5: An access qualifies only when ram_acc_n is 0, ram_sel bit q is 1 for quadrant q, and read-wait or write-wait is high. Otherwise the quadrant keeps its register-chosen pair.
- R6: The override applies only to quadrants whose select bit is set. Unselected quadrants follow the source register in the same cycle.
- R7: When read-wait and write-wait are both high on a qualified access, the read override applies.
- R8: A register write with reg_addr equal to 8'h18 stores reg_wdata[1:0] into the source register. reg_rdata returns the stored value whenever reg_addr is 8'h18.
- R9: A register write to any other address leaves the source register unchanged, and reg_rdata reads 2'b00 for any other address.
- R10: The enables change on the first clock edge after the inputs that cause them, and a new register value steers the enables from the edge after it is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_wait | input | 1 | Read-wait state of the bus access machine |
| wr_wait | input | 1 | Write-wait state of the bus access machine |
| ram_acc_n | input | 1 | Active-low code RAM access strobe |
| ram_sel | input | 4 | Track-code RAM select, bit q for quadrant q |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 2 | Register write data |
| reg_rdata | output | 2 | Register read data |
| bus_oe_n | output | 4 | Per-quadrant active-low enable of the bus-side buffer |
| ram_oe | output | 4 | Per-quadrant active-high enable of the RAM-side buffer |

## Verification
The steering is tried under all four source values in three conditions: with no access, with reads and with writes. This separates the idle mux path from the two forced paths.

Accesses are made with the strobe high, or with each select bit cleared alone, while the other conditions stay true. These cases show that each qualifying term matters and that quadrants do not leak into one another.

Cycles with both wait states high tell a read-priority design apart from one that ignores the ordering. Register writes at offsets next to 8'h18 show that the address compare is exact.

// File: rtl/tkc_pkg.sv
package tkc_pkg;
  localparam int TKC_SRC_W = 2;
  typedef logic [TKC_SRC_W-1:0] tkc_src_t;
  // idle pair {bus_oe_n, ram_oe}
  localparam tkc_src_t TKC_SRC_SIM  = 2'b00;
  localparam tkc_src_t TKC_SRC_BAD  = 2'b01;
  localparam tkc_src_t TKC_SRC_NONE = 2'b10;
  localparam tkc_src_t TKC_SRC_RAM  = 2'b11;
  localparam tkc_src_t TKC_SRC_RST  = TKC_SRC_NONE;
endpackage

// File: rtl/tkc_rst_sync.sv
module tkc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_nxt;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/tkc_src_reg.sv
module tkc_src_reg
  import tkc_pkg::*;
#(
  parameter int          AW  = 8,
  parameter logic [AW-1:0] OFS = 8'h18
) (
  input  logic          clk,
  input  logic          rst_q_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  tkc_src_t      reg_wdata,
  output tkc_src_t      reg_rdata,
  output tkc_src_t      src_q
);
  logic     hit;
  logic     upd_en;
  tkc_src_t src_nxt;

  always_comb begin
    hit     = (reg_addr == OFS);
    upd_en  = reg_we & hit;
    src_nxt = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    src_q <= TKC_SRC_RST;
    else if (upd_en) src_q <= src_nxt;
  end

  assign reg_rdata = hit ? src_q : '0;
endmodule

// File: rtl/tkc_quad_steer.sv
module tkc_quad_steer
  import tkc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_q_n,
  input  logic     rd_wait,
  input  logic     wr_wait,
  input  logic     ram_acc_n,
  input  logic     sel_bit,
  input  tkc_src_t src,
  output logic     bus_oe_n,
  output logic     ram_oe
);
  logic     acc;
  logic     rd_hit;
  logic     wr_hit;
  logic     rd_gate;
  logic     wr_gate;
  tkc_src_t lane_nxt;
  tkc_src_t lane_q;

  always_comb begin
    acc     = ~ram_acc_n & sel_bit;
    rd_hit  = acc & rd_wait;
    wr_hit  = acc & wr_wait & ~rd_wait;
    rd_gate = ~wr_hit;  // idles high, low only on write
    wr_gate = rd_hit;   // idles low, high only on read
  end

  // lane 1 = bus_oe_n, lane 0 = ram_oe
  for (genvar l = 0; l < TKC_SRC_W; l++) begin : g_lane
    always_comb begin
      lane_nxt[l] = src[l] ? rd_gate : wr_gate;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) lane_q <= TKC_SRC_RST;
    else          lane_q <= lane_nxt;
  end

  assign bus_oe_n = lane_q[1];
  assign ram_oe   = lane_q[0];
endmodule

// File: rtl/tkc_dir_arb.sv
module tkc_dir_arb
  import tkc_pkg::*;
#(
  parameter int            NQ  = 4,
  parameter int            AW  = 8,
  parameter logic [AW-1:0] OFS = 8'h18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_wait,
  input  logic          wr_wait,
  input  logic          ram_acc_n,
  input  logic [NQ-1:0] ram_sel,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [1:0]    reg_wdata,
  output logic [1:0]    reg_rdata,
  output logic [NQ-1:0] bus_oe_n,
  output logic [NQ-1:0] ram_oe
);
  logic     rst_q_n;
  tkc_src_t src_q;

  tkc_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  tkc_src_reg #(.AW(AW), .OFS(OFS)) u_src (
    .clk       (clk),
    .rst_q_n   (rst_q_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .src_q     (src_q)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_quad
    tkc_quad_steer u_steer (
      .clk       (clk),
      .rst_q_n   (rst_q_n),
      .rd_wait   (rd_wait),
      .wr_wait   (wr_wait),
      .ram_acc_n (ram_acc_n),
      .sel_bit   (ram_sel[q]),
      .src       (src_q),
      .bus_oe_n  (bus_oe_n[q]),
      .ram_oe    (ram_oe[q])
    );
  end
endmodule

// File: rtl/tkc_dir_arb_chk.sv
module tkc_dir_arb_chk #(
  parameter int            NQ  = 4,
  parameter int            AW  = 8,
  parameter logic [AW-1:0] OFS = 8'h18
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic          rd_wait,
  input logic          wr_wait,
  input logic          ram_acc_n,
  input logic [NQ-1:0] ram_sel,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [1:0]    reg_wdata,
  input logic [1:0]    src_q,
  input logic [NQ-1:0] bus_oe_n,
  input logic [NQ-1:0] ram_oe
);
  for (genvar q = 0; q < NQ; q++) begin : g_q
    AST_READ_OPENS_RAM: assert property (@(posedge clk) disable iff (!rst_q_n)
      (!ram_acc_n && ram_sel[q] && rd_wait) |=> (bus_oe_n[q] && ram_oe[q])); // R3
    AST_WRITE_OPENS_BUS: assert property (@(posedge clk) disable iff (!rst_q_n)
      (!ram_acc_n && ram_sel[q] && wr_wait && !rd_wait) |=> (!bus_oe_n[q] && !ram_oe[q])); // R4
    AST_IDLE_FOLLOWS_REG: assert property (@(posedge clk) disable iff (!rst_q_n)
      (ram_acc_n || !ram_sel[q] || (!rd_wait && !wr_wait))
      |=> ({bus_oe_n[q], ram_oe[q]} == $past(src_q))); // R5
  end

  AST_REG_STORE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (reg_we && reg_addr == OFS) |=> (src_q == $past(reg_wdata))); // R8
  AST_REG_OTHER_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!(reg_we && reg_addr == OFS)) |=> $stable(src_q)); // R9
endmodule

bind tkc_dir_arb tkc_dir_arb_chk #(.NQ(NQ), .AW(AW), .OFS(OFS)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .rd_wait   (rd_wait),
  .wr_wait   (wr_wait),
  .ram_acc_n (ram_acc_n),
  .ram_sel   (ram_sel),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .src_q     (src_q),
  .bus_oe_n  (bus_oe_n),
  .ram_oe    (ram_oe)
);

// File: tb/tb_tkc_dir_arb.sv
module tb_tkc_dir_arb;
  localparam int NQ = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rd_wait, wr_wait, ram_acc_n, reg_we;
  logic [NQ-1:0] ram_sel;
  logic [7:0]    reg_addr;
  logic [1:0]    reg_wdata;
  logic [1:0]    reg_rdata;
  logic [NQ-1:0] bus_oe_n, ram_oe;

  int total = 0;
  int bad   = 0;
  logic [1:0] src_m;
  bit done = 0;

  always #5 clk = ~clk;

  tkc_dir_arb dut (
    .clk(clk), .rst_n(rst_n), .rd_wait(rd_wait), .wr_wait(wr_wait),
    .ram_acc_n(ram_acc_n), .ram_sel(ram_sel), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_oe_n(bus_oe_n), .ram_oe(ram_oe)
  );

  // expected {bus_oe_n, ram_oe} of one quadrant
  function automatic logic [1:0] exp_pair(logic rd, logic wr, logic acc_n,
                                          logic sb, logic [1:0] src);
    logic acc;
    acc = !acc_n && sb;
    if (acc && rd)      return 2'b11;
    else if (acc && wr) return 2'b00;
    else                return src;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one cycle: drive, clock, compare
  task automatic step(string req, logic rd, logic wr, logic acc_n,
                      logic [NQ-1:0] sel, logic we, logic [7:0] addr,
                      logic [1:0] wd);
    logic [NQ-1:0] eb, er;
    @(negedge clk);
    rd_wait = rd; wr_wait = wr; ram_acc_n = acc_n; ram_sel = sel;
    reg_we = we; reg_addr = addr; reg_wdata = wd;
    for (int q = 0; q < NQ; q++) begin
      logic [1:0] p;
      p = exp_pair(rd, wr, acc_n, sel[q], src_m);
      eb[q] = p[1];
      er[q] = p[0];
    end
    @(posedge clk);
    #2;
    if (we && addr == 8'h18) src_m = wd;
    chk(req, {bus_oe_n, ram_oe}, {eb, er});
    chk("R8/R9 readback", reg_rdata, (addr == 8'h18) ? src_m : 2'b00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    done = 1;
  end

  initial begin
    rst_n = 1'b0; rd_wait = 0; wr_wait = 0; ram_acc_n = 1; ram_sel = '0;
    reg_we = 0; reg_addr = 8'h18; reg_wdata = 2'b00;
    src_m = 2'b10;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset rdata", reg_rdata, 2'b10);
    chk("R1 reset oe", {bus_oe_n, ram_oe}, {{NQ{1'b1}}, {NQ{1'b0}}});

    // R2 each idle value, R10 one-edge lag after write
    for (int v = 0; v < 4; v++) begin
      step("R10 write cycle", 0, 0, 1, '0, 1, 8'h18, v[1:0]);
      step("R2 idle mapping", 0, 0, 1, '0, 0, 8'h18, 2'b00);
    end
    // R3 / R4 under each source value
    for (int v = 0; v < 4; v++) begin
      step("R2 set", 0, 0, 1, '0, 1, 8'h18, v[1:0]);
      step("R3 read force", 1, 0, 0, 4'b1111, 0, 8'h18, 2'b00);
      step("R4 write force", 0, 1, 0, 4'b1111, 0, 8'h18, 2'b00);
      step("R7 read priority", 1, 1, 0, 4'b1111, 0, 8'h18, 2'b00);
      step("R5 strobe high", 1, 0, 1, 4'b1111, 0, 8'h18, 2'b00);
      step("R5 no wait", 0, 0, 0, 4'b1111, 0, 8'h18, 2'b00);
    end
    // R6 single quadrant select
    for (int q = 0; q < NQ; q++) begin
      step("R6 one quadrant read", 1, 0, 0, 4'(1 << q), 0, 8'h18, 2'b00);
      step("R6 one quadrant write", 0, 1, 0, 4'(1 << q), 0, 8'h18, 2'b00);
    end
    // R9 neighbouring offsets
    step("R9 other addr 17", 0, 0, 1, '0, 1, 8'h17, 2'b01);
    step("R9 other addr 19", 0, 0, 1, '0, 1, 8'h19, 2'b01);
    step("R9 other addr 1c", 0, 0, 1, '0, 1, 8'h1c, 2'b01);
    step("R9 other addr 98", 0, 0, 1, '0, 1, 8'h98, 2'b01);
    step("R9 hold", 0, 0, 1, '0, 0, 8'h18, 2'b00);

    // random mix
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      a = ($urandom % 2) ? 8'h18 : 8'($urandom);
      step("R2-R7 random", 1'($urandom), 1'($urandom), 1'($urandom % 3 == 0),
           4'($urandom), 1'($urandom % 4 == 0), a, 2'($urandom));
    end
    done = 1;
  end

  initial begin
    wait (done);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule